// File: doc/BRIEF.md
# Omega Tag Selector

This block is the control copy of an eight-port Omega network built from three columns of 2x2 switching elements. It does not move data. It moves only the 3-bit destination tag that each input port wants to send in the coming cell slot. It then reports which ports can send in that slot without contention on any output or internal link of the data-side network. A slot's selection runs over several contest rounds. A port that won an earlier round re-enters each later round with priority, so its path is held and the winner set can only grow. Contests between two fresh requests are settled by a seedable pseudo-random source.

The queue logic starts a selection with a one-cycle `start` pulse and holds each port's request valid flag and destination tag on the inputs. When `done` pulses, it reads the per-port grant flags. Each round evaluates one stage per clock and spends one further clock collecting the winners. With `two_pass` set, the rounds are split evenly between two passes, for a data fabric that runs at twice the line rate. In that mode each granted port is assigned to exactly one pass. Ports that won in the first pass, and the destinations they hold, are kept out of the second pass. The chosen pass is reported per port.

Top module: `omega_tag_selector`

## Requirements
- R1: Stage s (s = 0, 1, 2) first applies a perfect shuffle, which rotates the 3-bit lane position left by one bit. Lanes 2k and 2k+1 then meet in element k. The element steers each request by destination bit 2-s: a 0 goes to the even (upper) lane and a 1 goes to the odd (lower) lane. A request that meets no contest reaches the output equal to its destination and is granted. The identity pattern, with every port sending to its own number, is granted in full.
- R2: When two requests in one element want the same output lane, one is forwarded and the other is dropped for the rest of the round. Two ports with the same destination are never granted in the same pass.
- R3: Requests for different destinations that need a common internal link are not both granted in one pass. Example: port 0 to destination 0 and port 4 to destination 1 share element 0 of the first stage.
- R4: A port that won an earlier round of the current pass wins every later contest it meets. The winner set of a pass never shrinks. The grants of one pass use pairwise disjoint links in every stage.
- R5: `start` is accepted only while `busy` is low. `busy` rises on the next cycle. `done` is a one-cycle pulse exactly 4 x 2 x RPASS cycles after the accepting edge (40 by default). A `start` while busy is ignored. `grant` and `grant_pass` change only together with `done`.
- R6: With `two_pass` high, each pass runs RPASS rounds. First-pass winners take no part in the second pass, and their destinations are unavailable there. `grant_pass` bit i is 1 for a second-pass grant and 0 for a first-pass grant. With `two_pass` low, 2 x RPASS rounds run in a single pass and `grant_pass` is all zero.
- R7: A port whose `req_vld` bit is low is never granted.
- R8: Random contests draw from an LFSR. A `seed_load` pulse loads `seed` into it, and a zero seed is replaced by 1. The same seed with the same requests gives the same grants.
- R9: During and after reset, `busy`, `done`, `grant` and `grant_pass` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_load | input | 1 | Load `seed` into the arbitration LFSR |
| seed | input | 16 | LFSR seed value |
| start | input | 1 | Begin a slot selection (ignored while busy) |
| two_pass | input | 1 | Split rounds across two passes; sampled at start |
| req_vld | input | 8 | Per-port request valid |
| req_dst | input | 24 | Per-port destination tag, port i at bits [3i+2:3i] |
| busy | output | 1 | Selection in progress |
| done | output | 1 | One-cycle pulse when grants are updated |
| grant | output | 8 | Per-port grant flag |
| grant_pass | output | 8 | Per-port pass number of the grant (0 first, 1 second) |

## Verification
Two things can land in the same element in the same clock: a fresh request and an earlier winner that is holding its path. The first must lose to the second, and the random source must have no say. The bench provokes this with patterns that force repeated contests. One sends all eight ports to one destination. Another sends ports 0 and 4 to destinations that need the same first-stage link. Both patterns run in single-pass and two-pass modes, and random patterns follow. The bench judges the results at the ports: it counts the grants, replays the Omega path of every granted port to confirm no shared link per pass, and checks that the second pass avoids destinations taken in the first. Inside the design, assertions check that winners are never lost within a pass and that held destinations stay distinct.

// File: rtl/osel_pkg.sv
package osel_pkg;
  localparam int unsigned LOG_W = 3;
  localparam int unsigned NP    = 1 << LOG_W;
  localparam int unsigned BI_W  = (LOG_W > 1) ? $clog2(LOG_W) : 1;

  typedef struct packed {
    logic             vld;
    logic             pri;
    logic [LOG_W-1:0] src;
    logic [LOG_W-1:0] dst;
  } lane_t;
endpackage

// File: rtl/osel_lfsr.sv
module osel_lfsr #(
  parameter int unsigned   W     = 16,
  parameter logic [W-1:0]  TAPS  = 16'hB400,
  parameter int unsigned   OUT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [W-1:0]     seed,
  input  logic             en,
  output logic [OUT_W-1:0] bits
);
  logic [W-1:0] st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (load)     st_d = (seed == '0) ? W'(1) : seed;
    else if (en)  st_d = st_q[0] ? ((st_q >> 1) ^ TAPS) : (st_q >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          st_q <= W'(1);
    else if (load || en) st_q <= st_d;
  end

  assign bits = st_q[OUT_W-1:0];

  // R8: the generator never locks up in the all-zero state
  p_lfsr_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != '0);
endmodule

// File: rtl/osel_stage.sv
module osel_stage
  import osel_pkg::*;
(
  input  lane_t [NP-1:0]   lanes_i,
  input  logic  [BI_W-1:0] bit_idx,
  input  logic  [NP/2-1:0] coin,
  output lane_t [NP-1:0]   lanes_o
);
  lane_t [NP-1:0] shuf;

  // perfect shuffle: rotate the lane position left by one bit
  for (genvar p = 0; p < NP; p++) begin : g_shuf
    localparam int unsigned TO = ((p << 1) | (p >> (LOG_W - 1))) & (NP - 1);
    assign shuf[TO] = lanes_i[p];
  end

  // column of 2x2 elements
  for (genvar k = 0; k < NP/2; k++) begin : g_elem
    lane_t a, b;
    logic  ra, rb, clash, a_keep, a_up, a_dn, b_up, b_dn;
    assign a      = shuf[2*k];
    assign b      = shuf[2*k+1];
    assign ra     = |((a.dst >> bit_idx) & LOG_W'(1));
    assign rb     = |((b.dst >> bit_idx) & LOG_W'(1));
    assign clash  = a.vld & b.vld & (ra == rb);
    // a held path always beats a fresh request; otherwise the coin decides
    assign a_keep = a.pri | (~b.pri & coin[k]);
    assign a_up   = a.vld & ~ra & ~(clash & ~a_keep);
    assign a_dn   = a.vld &  ra & ~(clash & ~a_keep);
    assign b_up   = b.vld & ~rb & ~(clash &  a_keep);
    assign b_dn   = b.vld &  rb & ~(clash &  a_keep);
    assign lanes_o[2*k]   = a_up ? a : (b_up ? b : '0);
    assign lanes_o[2*k+1] = a_dn ? a : (b_dn ? b : '0);
  end
endmodule

// File: rtl/omega_tag_selector.sv
module omega_tag_selector
  import osel_pkg::*;
#(
  parameter int unsigned RPASS  = 5,
  parameter int unsigned SEED_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  seed_load,
  input  logic [SEED_W-1:0]     seed,
  input  logic                  start,
  input  logic                  two_pass,
  input  logic [NP-1:0]         req_vld,
  input  logic [NP*LOG_W-1:0]   req_dst,
  output logic                  busy,
  output logic                  done,
  output logic [NP-1:0]         grant,
  output logic [NP-1:0]         grant_pass
);
  localparam int unsigned RTOT    = 2 * RPASS;
  localparam int unsigned RC_W    = $clog2(RTOT + 1);
  localparam int unsigned PH_W    = $clog2(LOG_W + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(LOG_W);

  typedef logic [NP-1:0][LOG_W-1:0] dvec_t;

  logic            run_q, run_d, pass_q, pass_d, two_q, two_d, done_q, done_d;
  logic [RC_W-1:0] rc_q, rc_d, rc_last;
  logic [PH_W-1:0] ph_q, ph_d;
  lane_t [NP-1:0]  lanes_q, lanes_d, inj, stg_in, stg_out;
  logic [NP-1:0]   win_q, win_d, p1_q, p1_d, taken_q, taken_d;
  logic [NP-1:0]   grant_q, grant_d, gpass_q, gpass_d, rep_win, taken_new;
  dvec_t           wdst_q, wdst_d, rep_dst;
  logic [BI_W-1:0] bit_idx;
  logic [NP/2-1:0] coin;
  logic            ctl_en;

  // lane injection: held winners with priority, fresh eligible requests plain
  for (genvar g = 0; g < NP; g++) begin : g_inj
    logic [LOG_W-1:0] di;
    logic             fresh;
    assign di     = req_dst[g*LOG_W +: LOG_W];
    assign fresh  = req_vld[g] & ~p1_q[g] & ~taken_q[di];
    assign inj[g] = win_q[g] ? {1'b1, 1'b1, LOG_W'(g), wdst_q[g]}
                  : fresh    ? {1'b1, 1'b0, LOG_W'(g), di}
                  : '0;
  end

  assign stg_in  = (ph_q == '0) ? inj : lanes_q;
  assign bit_idx = BI_W'(int'(LOG_W) - 1 - int'(ph_q));

  osel_lfsr #(.W(SEED_W), .OUT_W(NP/2)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .load(seed_load), .seed(seed),
    .en(run_q), .bits(coin)
  );

  osel_stage u_stage (
    .lanes_i(stg_in), .bit_idx(bit_idx), .coin(coin), .lanes_o(stg_out)
  );

  // collect survivors of the last stage
  always_comb begin
    rep_win   = '0;
    rep_dst   = wdst_q;
    taken_new = '0;
    for (int o = 0; o < NP; o++) begin
      if (lanes_q[o].vld) begin
        rep_win[lanes_q[o].src] = 1'b1;
        rep_dst[lanes_q[o].src] = lanes_q[o].dst;
      end
    end
    for (int i = 0; i < NP; i++)
      if (rep_win[i] | win_q[i]) taken_new[rep_dst[i]] = 1'b1;
  end

  assign rc_last = two_q ? RC_W'(RPASS - 1) : RC_W'(RTOT - 1);

  always_comb begin
    run_d = run_q;  pass_d = pass_q;  two_d = two_q;  rc_d = rc_q;  ph_d = ph_q;
    lanes_d = lanes_q;  win_d = win_q;  wdst_d = wdst_q;  p1_d = p1_q;
    taken_d = taken_q;  done_d = 1'b0;  grant_d = grant_q;  gpass_d = gpass_q;
    if (!run_q) begin
      if (start) begin
        run_d = 1'b1;  pass_d = 1'b0;  two_d = two_pass;  rc_d = '0;  ph_d = '0;
        win_d = '0;  p1_d = '0;  taken_d = '0;
      end
    end else if (ph_q != PH_LAST) begin
      lanes_d = stg_out;
      ph_d    = ph_q + 1'b1;
    end else begin
      ph_d   = '0;
      win_d  = win_q | rep_win;
      wdst_d = rep_dst;
      if (rc_q != rc_last) begin
        rc_d = rc_q + 1'b1;
      end else if (two_q && !pass_q) begin
        pass_d  = 1'b1;
        rc_d    = '0;
        p1_d    = win_q | rep_win;
        taken_d = taken_new;
        win_d   = '0;
      end else begin
        run_d   = 1'b0;
        done_d  = 1'b1;
        grant_d = p1_q | win_q | rep_win;
        gpass_d = two_q ? (win_q | rep_win) : '0;
      end
    end
  end

  assign ctl_en = run_q | start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;  done_q <= 1'b0;  pass_q <= 1'b0;  two_q <= 1'b0;
      rc_q <= '0;  ph_q <= '0;  lanes_q <= '0;  win_q <= '0;  wdst_q <= '0;
      p1_q <= '0;  taken_q <= '0;  grant_q <= '0;  gpass_q <= '0;
    end else begin
      run_q  <= run_d;
      done_q <= done_d;
      if (ctl_en) begin
        pass_q <= pass_d;  two_q <= two_d;  rc_q <= rc_d;  ph_q <= ph_d;
        lanes_q <= lanes_d;  win_q <= win_d;  wdst_q <= wdst_d;
        p1_q <= p1_d;  taken_q <= taken_d;  grant_q <= grant_d;  gpass_q <= gpass_d;
      end
    end
  end

  assign busy       = run_q;
  assign done       = done_q;
  assign grant      = grant_q;
  assign grant_pass = gpass_q;

  // R1: every lane leaving the last stage sits on its own destination
  for (genvar o = 0; o < NP; o++) begin : g_route_chk
    p_route_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && ph_q == PH_LAST && lanes_q[o].vld) |-> (lanes_q[o].dst == LOG_W'(o)));
  end

  // R2: held winners of a pass never share a destination
  for (genvar i = 0; i < NP; i++) begin : g_pair_i
    for (genvar j = i + 1; j < NP; j++) begin : g_pair_j
      p_pair_dst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q[i] && win_q[j]) |-> (wdst_q[i] != wdst_q[j]));
    end
  end

  // R4: within a pass the winner set never loses a member
  p_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && pass_q == $past(pass_q)) |-> (($past(win_q) & ~win_q) == '0));

  // R5: an idle start launches a selection; done lasts one cycle
  p_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: pass bookkeeping
  p_single_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !two_q) |-> (grant_pass == '0));
  p_pass_sub_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((grant_pass & ~grant) == '0));
  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && pass_q) |-> ((win_q & p1_q) == '0));
endmodule

// File: tb/omega_tag_selector_test.sv
`timescale 1ns/1ps
module omega_tag_selector_test;
  localparam int NPORT = 8;
  localparam int LW    = 3;
  localparam int RP    = 5;
  localparam int LAT   = 4 * 2 * RP;

  logic                  clk, rst_n, seed_load, start, two_pass;
  logic [15:0]           seed;
  logic [NPORT-1:0]      req_vld;
  logic [NPORT*LW-1:0]   req_dst;
  logic                  busy, done;
  logic [NPORT-1:0]      grant, grant_pass;

  int checks = 0;
  int errors = 0;
  logic [31:0] rs = 32'h2545F491;

  omega_tag_selector #(.RPASS(RP)) uut (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed(seed),
    .start(start), .two_pass(two_pass), .req_vld(req_vld), .req_dst(req_dst),
    .busy(busy), .done(done), .grant(grant), .grant_pass(grant_pass)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int pop8(input logic [7:0] v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += int'(v[i]);
    return c;
  endfunction

  // replay Omega paths of a set of ports; 1 when no link is shared
  function automatic bit omega_ok(input logic [7:0] m, input logic [23:0] dv);
    logic [2:0] pos [8];
    for (int i = 0; i < 8; i++) pos[i] = 3'(i);
    for (int s = 0; s < 3; s++) begin
      for (int i = 0; i < 8; i++) begin
        pos[i] = {pos[i][1:0], dv[i*3 + (2 - s)]};
      end
      for (int i = 0; i < 8; i++)
        for (int j = i + 1; j < 8; j++)
          if (m[i] && m[j] && pos[i] == pos[j]) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic [7:0] dmask(input logic [7:0] m, input logic [23:0] dv);
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++) if (m[i]) r[dv[i*3 +: 3]] = 1'b1;
    return r;
  endfunction

  task automatic finish_up;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic run_slot(input logic tp, input int poke, output int n);
    @(negedge clk);
    two_pass = tp;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    chk(busy === 1'b1, "R5 busy after start", 32'(busy), 32'd1);
    while (done !== 1'b1 && n < 400) begin
      if (poke > 0 && n == poke) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n++;
    end
  endtask

  task automatic load_seed(input logic [15:0] s);
    @(negedge clk);
    seed = s;
    seed_load = 1'b1;
    @(negedge clk);
    seed_load = 1'b0;
  endtask

  task automatic t_reset;
    chk(busy === 1'b0 && done === 1'b0, "R9 busy/done in reset", {busy, done}, 32'd0);
    chk(grant === '0 && grant_pass === '0, "R9 grants in reset", {grant, grant_pass}, 32'd0);
  endtask

  task automatic t_identity(input logic tp);
    int n;
    logic [23:0] dv;
    for (int i = 0; i < 8; i++) dv[i*3 +: 3] = 3'(i);
    req_vld = 8'hFF; req_dst = dv;
    run_slot(tp, 0, n);
    chk(n == LAT, "R5 latency identity", 32'(n), 32'(LAT));
    chk(grant === 8'hFF, "R1 identity all granted", 32'(grant), 32'hFF);
    chk(grant_pass === 8'h00, "R6 identity all in pass one", 32'(grant_pass), 32'h0);
  endtask

  task automatic t_single;
    int n;
    req_vld = 8'h20; req_dst = {8{3'd2}};
    run_slot(1'b0, 0, n);
    chk(grant === 8'h20, "R1 lone request granted, R7 invalid ports not", 32'(grant), 32'h20);
    req_vld = 8'h00;
    run_slot(1'b0, 0, n);
    chk(grant === 8'h00, "R7 no valid request no grant", 32'(grant), 32'h0);
  endtask

  task automatic t_blocking;
    int n;
    logic [23:0] dv = '0;
    dv[12 +: 3] = 3'd1;
    req_vld = 8'h11; req_dst = dv;
    run_slot(1'b0, 0, n);
    chk(pop8(grant) == 1 && (grant & 8'hEE) == 0, "R3 link-sharing pair one grant", 32'(grant), 32'h1);
    chk(grant_pass === 8'h00, "R6 single mode pass zero", 32'(grant_pass), 32'h0);
    run_slot(1'b1, 0, n);
    chk(grant === 8'h11, "R6 pair both granted over two passes", 32'(grant), 32'h11);
    chk(pop8(grant_pass) == 1 && (grant_pass & 8'hEE) == 0, "R6 pair split across passes", 32'(grant_pass), 32'h1);
  endtask

  task automatic t_hotspot;
    int n;
    req_vld = 8'hFF; req_dst = {8{3'd3}};
    run_slot(1'b0, 0, n);
    chk(pop8(grant) == 1, "R2 hotspot single pass one winner", 32'(pop8(grant)), 32'd1);
    run_slot(1'b1, 0, n);
    chk(pop8(grant) == 1, "R6 hotspot destination blocked in pass two", 32'(pop8(grant)), 32'd1);
    chk(grant_pass === 8'h00, "R6 hotspot winner in pass one", 32'(grant_pass), 32'h0);
  endtask

  task automatic t_busy_start;
    int n;
    logic [23:0] dv;
    for (int i = 0; i < 8; i++) dv[i*3 +: 3] = 3'(7 - i);
    req_vld = 8'hFF; req_dst = dv;
    run_slot(1'b0, 10, n);
    chk(n == LAT, "R5 start while busy ignored", 32'(n), 32'(LAT));
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R5 done one cycle, idle after", {done, busy}, 32'd0);
    chk(omega_ok(grant, dv), "R4 reversal grants link-disjoint", 32'(grant), 32'(grant));
  endtask

  task automatic t_seed;
    int n;
    logic [7:0] g1;
    req_vld = 8'hFF; req_dst = {8{3'd5}};
    load_seed(16'h1234);
    run_slot(1'b0, 0, n);
    g1 = grant;
    load_seed(16'h1234);
    run_slot(1'b0, 0, n);
    chk(grant === g1, "R8 same seed same grants", 32'(grant), 32'(g1));
    load_seed(16'h0000);
    run_slot(1'b0, 0, n);
    chk(pop8(grant) == 1, "R8 zero seed still arbitrates", 32'(pop8(grant)), 32'd1);
  endtask

  task automatic t_random(input logic tp, input int reps);
    int n;
    logic [7:0] p1, p2;
    for (int r = 0; r < reps; r++) begin
      rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
      req_vld = rs[7:0] | 8'h01;
      rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
      req_dst = rs[23:0];
      run_slot(tp, 0, n);
      p2 = grant_pass;
      p1 = grant & ~grant_pass;
      chk(n == LAT, "R5 latency random", 32'(n), 32'(LAT));
      chk((grant & ~req_vld) == 0, "R7 grants only valid ports", 32'(grant), 32'(grant & req_vld));
      chk(omega_ok(p1, req_dst) && omega_ok(p2, req_dst), "R4 per-pass link-disjoint", {p1, p2}, {p1, p2});
      chk((dmask(p1, req_dst) & dmask(p2, req_dst)) == 0, "R6 pass two avoids pass one destinations",
          32'(dmask(p2, req_dst)), 32'(dmask(p2, req_dst) & ~dmask(p1, req_dst)));
      chk(pop8(grant) >= 1, "R1 some request always granted", 32'(pop8(grant)), 32'd1);
      if (!tp) chk(grant_pass === 8'h00, "R6 single mode pass zero random", 32'(grant_pass), 32'h0);
    end
  endtask

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; seed_load = 1'b0; seed = 16'hACE1; start = 1'b0; two_pass = 1'b0;
    req_vld = '0; req_dst = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    load_seed(16'hACE1);
    t_identity(1'b0);
    t_identity(1'b1);
    t_single();
    t_blocking();
    t_hotspot();
    t_busy_start();
    t_seed();
    t_random(1'b0, 8);
    t_random(1'b1, 8);
    finish_up();
  end
endmodule